// File: doc/BRIEF.md
# Serial Transmitter with Handshake-Cleared Status

This block sends bytes over an asynchronous serial line and reports its state through a byte-wide status register. Software writes a byte into a holding register. The frame machine moves that byte into its own shift register and sends it as one frame:

- a low start bit,
- eight data bits, least significant bit first,
- a high stop bit.

Each bit lasts `OVS` ticks of the external transmit tick. The block can also send two special frames on request: an idle preamble, which is ten high bit times, and a break, which is nine low bit times followed by a high stop bit.

The holding-register-empty flag does not clear on any single access. A status read must first see the flag set, and only a later write to the data address clears it. Until that happens a byte is not queued. The send-done flag is high only when the holding register is empty, no frame is on the line, and no preamble or break is pending. The upper two status bits carry these transmitter flags. The lower six bits pass six receiver flags straight through. A control register holds three interrupt enables.

The frame machine has four states:

- `ST_IDLE`: the line is high and the machine waits for work.
- `ST_START`: the start bit.
- `ST_DATA`: eight data bits.
- `ST_STOP`: the stop bit.

Its transitions are:

- launch: `ST_IDLE` goes to `ST_START` on a tick while enabled with work pending.
- start end: `ST_START` goes to `ST_DATA`.
- last bit: `ST_DATA` goes to `ST_STOP`.
- chain: `ST_STOP` goes to `ST_START` when more work is pending at the end of the stop bit.
- finish: `ST_STOP` goes to `ST_IDLE` when nothing is pending.
- abort: any state goes to `ST_IDLE` when `en` is low.

Top module: `sertx_core`

## Requirements
- R1: After reset, status reads 8'hC0 with receiver inputs low, and the control register reads 0. Status bit 7 is empty, bit 6 is done, and bits 5..0 are `rx_flags[5:0]` unchanged. The register addresses are 0 for control, 1 for status and 2 for data.
- R2: Empty (status bit 7) sets in the cycle after the frame machine takes the held byte into its shift register.
- R3: Empty clears only on a data write made while armed. A status read that sees empty set arms the handshake. Writes to the control or status address leave the armed state unchanged. A data write without arming leaves empty set and queues nothing.
- R4: Done (status bit 6) is high exactly when empty is set, no frame is in progress, and no preamble or break is pending. It drops in the cycle after a data write or a frame request queues work.
- R5: A data frame is a low start bit, then eight data bits LSB first, then a high stop bit, each lasting `OVS` ticks.
- R6: A preamble frame holds the line high for ten bit times. A break frame holds it low for nine bit times, then high for one stop bit.
- R7: A queued frame starts on the first tick after it is queued, which is within 1.5 tick periods.
- R8: `tx_irq` is (empty AND control bit 0) OR (done AND control bit 1).
- R9: `err_irq` is `rx_flags[0]` AND control bit 2, and the enable is cleared by reset.
- R10: `txd` is high while idle. While `en` is low, no frame starts and `txd` is high. Dropping `en` mid-frame returns the line high on the next cycle.
- R11: Writes to the status address change neither status nor control.
- R12: When several kinds of work are pending at a frame start, break goes first, then preamble, then data. Frames chain back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Transmitter enable |
| tick | input | 1 | Transmit clock tick; one bit lasts OVS ticks |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pre_req | input | 1 | Pulse to queue a preamble frame |
| brk_req | input | 1 | Pulse to queue a break frame |
| rx_flags | input | 6 | Receiver flags shown in status bits 5..0 |
| txd | output | 1 | Serial line |
| tx_irq | output | 1 | Transmit interrupt request |
| err_irq | output | 1 | Parity-error interrupt request |
| status | output | 8 | Status byte |

## Verification
The bench aims at the clear handshake from several directions:

- A data write with no prior status read must leave empty set and the line quiet. A design that clears on any data write would start a frame.
- Control and status writes placed between the arming read and the data write must not disarm. A design that forgets the arm would never send that byte.

Done is sampled one cycle after queueing and one cycle before and after the stop bit ends. An off-by-one frame length or a done flag that ignores pending requests shows up there.

Three frame kinds are queued while disabled, then released at once. A wrong priority or a gap between chained frames misplaces bits in the second and third frames.

A sparse tick measures start latency, which catches a design that waits a whole extra bit time before starting.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;
    localparam int RXF_W  = 6;
    localparam int CTL_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

    localparam int IE_EMPTY = 0;
    localparam int IE_DONE  = 1;
    localparam int IE_PERR  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } fr_state_e;

    typedef enum logic [1:0] {
        FK_DATA = 2'd0,
        FK_PRE  = 2'd1,
        FK_BRK  = 2'd2
    } fr_kind_e;
endpackage

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             have_data,
    input  logic             pend_pre,
    input  logic             pend_brk,
    input  logic [BUS_W-1:0] hold,
    output logic             txd,
    output logic             busy,
    output logic             take_data,
    output logic             take_pre,
    output logic             take_brk
);
    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam int IDX_W = $clog2(BUS_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BUS_W - 1);

    fr_state_e        st_q, st_d;
    fr_kind_e         kind_q, kind_d, pick;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [BUS_W-1:0] shf_q, shf_d, pick_bits;
    logic             bit_end, work, launch;

    // selection of the next frame: break, then preamble, then data
    always_comb begin
        bit_end = tick && (cnt_q == CNT_LAST);
        work    = pend_brk || pend_pre || have_data;
        if (pend_brk) begin
            pick      = FK_BRK;
            pick_bits = '0;
        end else if (pend_pre) begin
            pick      = FK_PRE;
            pick_bits = '1;
        end else begin
            pick      = FK_DATA;
            pick_bits = hold;
        end
        launch    = en && tick && work &&
                    ((st_q == ST_IDLE) || ((st_q == ST_STOP) && bit_end));
        take_data = launch && (pick == FK_DATA);
        take_pre  = launch && (pick == FK_PRE);
        take_brk  = launch && (pick == FK_BRK);
    end

    // next-state logic
    always_comb begin
        st_d   = st_q;
        kind_d = kind_q;
        cnt_d  = cnt_q;
        idx_d  = idx_q;
        shf_d  = shf_q;
        if (!en) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (launch) begin
                        st_d   = ST_START;
                        cnt_d  = '0;
                        kind_d = pick;
                        shf_d  = pick_bits;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (bit_end) begin
                            st_d  = ST_DATA;
                            cnt_d = '0;
                            idx_d = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (bit_end) begin
                            cnt_d = '0;
                            shf_d = shf_q >> 1;
                            if (idx_q == IDX_LAST) begin
                                st_d = ST_STOP;
                            end else begin
                                idx_d = idx_q + 1'b1;
                            end
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (bit_end) begin
                            cnt_d = '0;
                            if (launch) begin
                                st_d   = ST_START;
                                kind_d = pick;
                                shf_d  = pick_bits;
                            end else begin
                                st_d = ST_IDLE;
                            end
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            kind_q <= FK_DATA;
            cnt_q  <= '0;
            idx_q  <= '0;
            shf_q  <= '0;
        end else begin
            st_q   <= st_d;
            kind_q <= kind_d;
            cnt_q  <= cnt_d;
            idx_q  <= idx_d;
            shf_q  <= shf_d;
        end
    end

    // outputs
    always_comb begin
        busy = (st_q != ST_IDLE);
        unique case (st_q)
            ST_IDLE:  txd = 1'b1;
            ST_START: txd = (kind_q == FK_PRE);
            ST_DATA:  txd = shf_q[0];
            ST_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

    // R10: disable forces the line high and the machine idle
    p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (txd && !busy));
    // R7: a frame only starts on a tick while enabled
    p_launch_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tick && en));
    // R6: break data bits are low
    p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && kind_q == FK_BRK) |-> !txd);
    // R12: at most one frame kind taken at once
    p_one_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_data, take_pre, take_brk}));
endmodule

// File: rtl/sertx_regs.sv
module sertx_regs
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              pre_req,
    input  logic              brk_req,
    input  logic [RXF_W-1:0]  rx_flags,
    input  logic              take_data,
    input  logic              take_pre,
    input  logic              take_brk,
    input  logic              busy,
    output logic [BUS_W-1:0]  rdata,
    output logic [BUS_W-1:0]  status,
    output logic              tx_irq,
    output logic              err_irq,
    output logic              have_data,
    output logic [BUS_W-1:0]  hold,
    output logic              pend_pre,
    output logic              pend_brk
);
    logic [CTL_W-1:0] ctrl_q;
    logic             empty_q, armed_q, pre_q, brk_q;
    logic [BUS_W-1:0] hold_q;
    logic             wr_data, wr_ctl, rd_stat, done;

    always_comb begin
        wr_data = wr_en && (addr == A_DATA);
        wr_ctl  = wr_en && (addr == A_CTRL);
        rd_stat = rd_en && (addr == A_STAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            empty_q <= 1'b1;
            armed_q <= 1'b0;
            hold_q  <= '0;
            pre_q   <= 1'b0;
            brk_q   <= 1'b0;
        end else begin
            if (wr_ctl) ctrl_q <= wdata[CTL_W-1:0];
            if (wr_data && empty_q) hold_q <= wdata;
            if (take_data) begin
                empty_q <= 1'b1;
            end else if (wr_data && armed_q) begin
                empty_q <= 1'b0;
            end
            if (wr_data && armed_q) begin
                armed_q <= 1'b0;
            end else if (rd_stat && empty_q) begin
                armed_q <= 1'b1;
            end
            pre_q <= (pre_q && !take_pre) || pre_req;
            brk_q <= (brk_q && !take_brk) || brk_req;
        end
    end

    always_comb begin
        done      = empty_q && !busy && !pre_q && !brk_q;
        status    = {empty_q, done, rx_flags};
        tx_irq    = (empty_q && ctrl_q[IE_EMPTY]) || (done && ctrl_q[IE_DONE]);
        err_irq   = rx_flags[0] && ctrl_q[IE_PERR];
        have_data = !empty_q;
        hold      = hold_q;
        pend_pre  = pre_q;
        pend_brk  = brk_q;
        if (addr == A_CTRL) begin
            rdata = {{(BUS_W-CTL_W){1'b0}}, ctrl_q};
        end else if (addr == A_STAT) begin
            rdata = status;
        end else begin
            rdata = '0;
        end
    end

    // R3: empty clears only from the armed state
    p_empty_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty_q) |-> $past(armed_q));
    // R3: armed implies empty
    p_armed_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> empty_q);
    // R2: empty sets only when the frame machine takes the byte
    p_empty_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_q) |-> $past(take_data));
    // R2: the frame machine takes data only when a byte is queued
    p_take_queued_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_data |-> !empty_q);
    // R4: done is low while a frame is on the line
    p_done_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !status[6]);
endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              pre_req,
    input  logic              brk_req,
    input  logic [RXF_W-1:0]  rx_flags,
    output logic              txd,
    output logic              tx_irq,
    output logic              err_irq,
    output logic [BUS_W-1:0]  status
);
    logic             have_data, pend_pre, pend_brk, busy;
    logic             take_data, take_pre, take_brk;
    logic [BUS_W-1:0] hold;

    sertx_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .pre_req   (pre_req),
        .brk_req   (brk_req),
        .rx_flags  (rx_flags),
        .take_data (take_data),
        .take_pre  (take_pre),
        .take_brk  (take_brk),
        .busy      (busy),
        .rdata     (rdata),
        .status    (status),
        .tx_irq    (tx_irq),
        .err_irq   (err_irq),
        .have_data (have_data),
        .hold      (hold),
        .pend_pre  (pend_pre),
        .pend_brk  (pend_brk)
    );

    sertx_fsm #(.OVS(OVS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .have_data (have_data),
        .pend_pre  (pend_pre),
        .pend_brk  (pend_brk),
        .hold      (hold),
        .txd       (txd),
        .busy      (busy),
        .take_data (take_data),
        .take_pre  (take_pre),
        .take_brk  (take_brk)
    );
endmodule

// File: tb/sertx_core_bench.sv
module sertx_core_bench;
    import sertx_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n, en, rd_en, wr_en, pre_req, brk_req;
    logic       tick = 1'b0;
    logic [1:0] addr;
    logic [7:0] wdata, rdata, status;
    logic [5:0] rx_flags;
    logic       txd, tx_irq, err_irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int tick_div = 1;
    int tcnt = 0;
    bit done = 1'b0;

    // {byte, expected line per bit time, bit 0 first}
    localparam logic [17:0] VEC [4] = '{
        {8'h00, 10'b1000000000},
        {8'hFF, 10'b1111111110},
        {8'hA5, 10'b1101001010},
        {8'h3C, 10'b1001111000}
    };

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (tcnt >= tick_div - 1) begin
            tcnt <= 0;
            tick <= 1'b1;
        end else begin
            tcnt <= tcnt + 1;
            tick <= 1'b0;
        end
    end

    sertx_core u_sertx_core (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pre_req(pre_req), .brk_req(brk_req),
        .rx_flags(rx_flags), .txd(txd), .tx_irq(tx_irq),
        .err_irq(err_irq), .status(status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic at_cycle(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic queue_byte(input logic [7:0] b, output int s);
        logic [7:0] st;
        bus_rd(A_STAT, st);
        bus_wr(A_DATA, b);
        s = cyc + 1;
    endtask

    task automatic req_pulse(input bit brk, output int s);
        if (brk) brk_req = 1'b1; else pre_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0; pre_req = 1'b0;
        s = cyc + 1;
    endtask

    task automatic check_frame(input int s, input logic [9:0] exp, input string req);
        logic [9:0] got;
        for (int k = 0; k < 10; k++) begin
            at_cycle(s + 8 + 16 * k);
            got[k] = txd;
        end
        chk(got == exp, req, got, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        int s, lat, w;
        bit quiet;
        rst_n = 1'b0; en = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
        pre_req = 1'b0; brk_req = 1'b0; addr = '0; wdata = '0; rx_flags = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and flag passthrough
        chk(status == 8'hC0, "R1", status, 8'hC0);
        bus_rd(A_CTRL, rv);
        chk(rv == 8'h00, "R1", rv, 0);
        chk(txd == 1'b1 && tx_irq == 1'b0 && err_irq == 1'b0, "R1", {txd, tx_irq, err_irq}, 3'b100);
        rx_flags = 6'b101101;
        #1 chk(status == 8'hED, "R1", status, 8'hED);
        rx_flags = '0;

        // R3 data write without arming read queues nothing
        bus_wr(A_DATA, 8'h55);
        quiet = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (txd !== 1'b1 || status[7:6] !== 2'b11) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet, "R3", quiet, 1);

        // R5 / R2 / R4 table of data frames
        for (int i = 0; i < 4; i++) begin
            queue_byte(VEC[i][17:10], s);
            chk(status[7:6] == 2'b00, "R3", status[7:6], 0);
            at_cycle(s + 1);
            chk(status[7:6] == 2'b10, "R2", status[7:6], 2);
            check_frame(s, VEC[i][9:0], "R5");
            at_cycle(s + 159);
            chk(status[6] == 1'b0, "R4", status[6], 0);
            at_cycle(s + 160);
            chk(status[6] == 1'b1, "R4", status[6], 1);
        end

        // R11 status write ignored; R3 arm survives other writes
        bus_rd(A_STAT, rv);
        bus_wr(A_STAT, 8'h00);
        bus_wr(A_CTRL, 8'h00);
        chk(status == 8'hC0, "R11", status, 8'hC0);
        bus_wr(A_DATA, 8'h0F);
        s = cyc + 1;
        chk(status[7] == 1'b0, "R3", status[7], 0);
        check_frame(s, 10'b1000011110, "R3");
        at_cycle(s + 160);

        // R6 preamble and break
        req_pulse(1'b0, s);
        chk(status[7:6] == 2'b10, "R4", status[7:6], 2);
        check_frame(s, 10'h3FF, "R6");
        at_cycle(s + 160);
        chk(status[6] == 1'b1, "R6", status[6], 1);
        req_pulse(1'b1, s);
        check_frame(s, 10'b1000000000, "R6");
        at_cycle(s + 160);

        // R12 priority and chaining; R10 held off while disabled
        en = 1'b0;
        req_pulse(1'b0, s);
        req_pulse(1'b1, s);
        queue_byte(8'hFF, s);
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (txd !== 1'b1 || status[6] !== 1'b0) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet, "R10", quiet, 1);
        en = 1'b1;
        s = cyc + 1;
        check_frame(s, 10'b1000000000, "R12");
        check_frame(s + 160, 10'h3FF, "R12");
        check_frame(s + 320, 10'b1111111110, "R12");
        at_cycle(s + 480);
        chk(status[6] == 1'b1, "R12", status[6], 1);

        // R8 transmit interrupt
        bus_wr(A_CTRL, 8'h01);
        chk(tx_irq == 1'b1, "R8", tx_irq, 1);
        bus_wr(A_CTRL, 8'h02);
        chk(tx_irq == 1'b1, "R8", tx_irq, 1);
        queue_byte(8'hAA, s);
        at_cycle(s + 40);
        chk(tx_irq == 1'b0, "R8", tx_irq, 0);
        bus_wr(A_CTRL, 8'h01);
        chk(tx_irq == 1'b1, "R8", tx_irq, 1);
        bus_wr(A_CTRL, 8'h00);
        at_cycle(s + 160);

        // R9 parity interrupt gate
        rx_flags = 6'b000001;
        #1 chk(err_irq == 1'b0, "R9", err_irq, 0);
        bus_wr(A_CTRL, 8'h04);
        chk(err_irq == 1'b1, "R9", err_irq, 1);
        rx_flags = '0;
        #1 chk(err_irq == 1'b0, "R9", err_irq, 0);
        bus_wr(A_CTRL, 8'h00);

        // R10 abort mid-frame
        queue_byte(8'h00, s);
        at_cycle(s + 30);
        chk(txd == 1'b0, "R10", txd, 0);
        en = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1 && status[6] == 1'b1, "R10", {txd, status[6]}, 3);
        en = 1'b1;
        repeat (2) @(negedge clk);

        // R7 start latency with a sparse tick
        tick_div = 4;
        repeat (8) @(negedge clk);
        queue_byte(8'h00, s);
        lat = 0;
        while (txd && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat >= 1 && lat <= 6, "R7", lat, 6);
        w = 0;
        while (!status[6] && w < 2000) begin
            @(negedge clk);
            w++;
        end
        chk(status[6] == 1'b1, "R7", status[6], 1);
        tick_div = 1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule